// File: doc/BRIEF.md
# Per-Channel Control Bit Serializer

This block turns a field of one-bit control flags, one flag per output stream and channel, into a single serial control line. Each frame it walks the flag memory in a fixed order and presents one flag per bit clock. The line is locked to the time-division output streams, so a downstream device can sample it together with the data. The flag memory holds sixteen output streams. A stream carries 32, 64 or 128 channels, depending on the rate mode.

Each flag leads its data channel by one whole channel slot. During the slot numbered s, the block sends the flags of channel s+1 for all sixteen streams, in stream order. The last slot of the frame carries the flags of channel 0 of the frame that follows. The flag memory is external and has a synchronous read port with one cycle of latency. The block issues each read address one clock before the bit it needs.

Top module: `ccs_serializer`

## Requirements
- R1: After reset and until the first frame pulse, `ctl_out` and `mem_rd_en` stay low, whatever `rate_sel` does.
- R2: `rate_sel` selects the frame length: 0 gives 512 bits, 1 gives 1024 bits, 2 gives 2048 bits. The value 3 behaves like 2.
- R3: Serial position p carries stream p mod 16, and its channel slot is p div 16. Inside a slot, streams 0 to 15 appear in ascending order.
- R4: The flag at position p is read from address stream × C + ((slot + 1) mod C), where C is 32, 64 or 128 for modes 0, 1 and 2. The last slot of the frame therefore reads channel 0.
- R5: A flag of 1 drives `ctl_out` high, and a flag of 0 drives it low.
- R6: When `frame_sync` is high in cycle t, the block reads the address for position 0 in cycle t. Position 0 appears on `ctl_out` in cycle t+1, and position k appears in cycle t+1+k.
- R7: When no new frame pulse arrives, the position wraps from the last position back to 0, and the same rate mode continues.
- R8: `rate_sel` is sampled only in a cycle where `frame_sync` is high. Changes at any other time have no effect until the next pulse.
- R9: A frame pulse in the middle of a frame restarts the sequence at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the serial control line |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Frame pulse. High for one cycle, in the cycle before bit 0 |
| rate_sel | input | 2 | Rate mode select (0, 1, 2; 3 behaves as 2) |
| mem_rdata | input | 1 | Flag returned by the memory one cycle after the address |
| mem_addr | output | 11 | Flag memory read address |
| mem_rd_en | output | 1 | Read strobe for the flag memory |
| ctl_out | output | 1 | Serial control output |

## Verification
The frame pulse is the stimulus. Its result comes through two registers: the registered read of the flag memory, and the output valid flag that is clocked in the same cycle. Position k is therefore due on `ctl_out` k+1 clocks after the pulse cycle. The driver drives the pulse on a falling edge and, in that same step, queues the expected bit for every position of the run. The monitor pops one item per rising edge and samples 2 ns after that edge, so queue item k lines up with position k without any counting in the monitor. The checks for the state before the first pulse sample on falling edges with no pulse pending.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  // Maps any select code at or above the mode count onto the fastest mode.
  function automatic int clamp_mode(input int sel, input int modes);
    return (sel >= modes) ? modes - 1 : sel;
  endfunction

  // Channels carried by one stream in a given rate mode.
  function automatic int ch_per_stream(input int base_ch, input int mode);
    return base_ch << mode;
  endfunction

  // Serial bits in one frame.
  function automatic int frame_bits(input int streams, input int base_ch, input int mode);
    return streams * ch_per_stream(base_ch, mode);
  endfunction

  // Flag address for serial position pos: the stream is interleaved fastest,
  // and the channel leads the current slot by one (mod channels per stream).
  function automatic int map_addr(input int pos, input int streams,
                                  input int base_ch, input int mode);
    int ch;
    int stream;
    int slot;
    int nxt;
    ch     = ch_per_stream(base_ch, mode);
    stream = pos % streams;
    slot   = pos / streams;
    nxt    = (slot + 1) % ch;
    return stream * ch + nxt;
  endfunction

endpackage

// File: rtl/ccs_frame_counter.sv
module ccs_frame_counter #(
  parameter int NUM_STREAMS = 16,
  parameter int BASE_CH     = 32,
  parameter int NUM_MODES   = 3,
  parameter int MODE_W      = 2,
  parameter int POS_W       = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic [MODE_W-1:0] rate_sel,
  output logic [POS_W-1:0]  rd_pos,
  output logic [MODE_W-1:0] rd_mode,
  output logic              active,
  output logic              frame_wrap
);
  import ccs_pkg::*;

  logic [POS_W-1:0]  pos_q;
  logic [MODE_W-1:0] mode_q;
  logic              locked_q;
  logic [POS_W-1:0]  last_pos;

  // A pulse overrides the running state in the same cycle, so the read for
  // position 0 goes out one clock ahead of its bit.
  assign rd_mode    = frame_sync ? MODE_W'(clamp_mode(int'(rate_sel), NUM_MODES)) : mode_q;
  assign rd_pos     = frame_sync ? '0 : pos_q;
  assign last_pos   = POS_W'(frame_bits(NUM_STREAMS, BASE_CH, int'(rd_mode)) - 1);
  assign active     = frame_sync | locked_q;
  assign frame_wrap = active & (rd_pos == last_pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q    <= '0;
      mode_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      if (active) pos_q <= frame_wrap ? '0 : rd_pos + POS_W'(1);
      mode_q <= rd_mode;
      if (frame_sync) locked_q <= 1'b1;
    end
  end

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (pos_q == POS_W'(1)));

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wrap && !frame_sync) |=> (pos_q == '0));

  p_rate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> $stable(mode_q));

  p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> (int'(pos_q) < frame_bits(NUM_STREAMS, BASE_CH, int'(mode_q))));

endmodule

// File: rtl/ccs_addr_map.sv
module ccs_addr_map #(
  parameter int NUM_STREAMS = 16,
  parameter int BASE_CH     = 32,
  parameter int NUM_MODES   = 3,
  parameter int MODE_W      = 2,
  parameter int POS_W       = 11,
  parameter int ADDR_W      = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [POS_W-1:0]  pos,
  input  logic [MODE_W-1:0] mode,
  output logic [ADDR_W-1:0] addr
);
  import ccs_pkg::*;

  localparam int SEL_N = 1 << MODE_W;

  logic [ADDR_W-1:0] cand [SEL_N];

  // One constant-geometry mapper per select code. Unused codes fold onto the last mode.
  for (genvar m = 0; m < SEL_N; m++) begin : g_mode
    localparam int MODE_M = (m < NUM_MODES) ? m : NUM_MODES - 1;
    always_comb cand[m] = ADDR_W'(map_addr(int'(pos), NUM_STREAMS, BASE_CH, MODE_M));
  end

  assign addr = cand[mode];

  p_addr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (int'(addr) < frame_bits(NUM_STREAMS, BASE_CH, int'(mode))));

  p_last_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && int'(pos) >= frame_bits(NUM_STREAMS, BASE_CH, int'(mode)) - NUM_STREAMS)
    |-> ((int'(addr) & (ch_per_stream(BASE_CH, int'(mode)) - 1)) == 0));

endmodule

// File: rtl/ccs_out_stage.sv
module ccs_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic mem_rdata,
  output logic ctl_out
);
  logic out_vld_q;

  // The valid flag tracks the one-cycle read latency of the flag memory.
  always_ff @(posedge clk) begin
    if (!rst_n) out_vld_q <= 1'b0;
    else        out_vld_q <= active;
  end

  assign ctl_out = out_vld_q & mem_rdata;

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !ctl_out);

  p_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (ctl_out == mem_rdata));

endmodule

// File: rtl/ccs_serializer.sv
module ccs_serializer #(
  parameter int NUM_STREAMS = 16,
  parameter int BASE_CH     = 32,
  parameter int NUM_MODES   = 3,
  parameter int MODE_W      = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1,
  parameter int ADDR_W      = $clog2(NUM_STREAMS * (BASE_CH << (NUM_MODES - 1)))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic [MODE_W-1:0] rate_sel,
  input  logic              mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              ctl_out
);
  localparam int POS_W = ADDR_W;

  logic [POS_W-1:0]  rd_pos;
  logic [MODE_W-1:0] rd_mode;
  logic              active;
  logic              frame_wrap;

  ccs_frame_counter #(
    .NUM_STREAMS(NUM_STREAMS), .BASE_CH(BASE_CH), .NUM_MODES(NUM_MODES),
    .MODE_W(MODE_W), .POS_W(POS_W)
  ) u_counter (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rate_sel(rate_sel),
    .rd_pos(rd_pos), .rd_mode(rd_mode), .active(active), .frame_wrap(frame_wrap)
  );

  ccs_addr_map #(
    .NUM_STREAMS(NUM_STREAMS), .BASE_CH(BASE_CH), .NUM_MODES(NUM_MODES),
    .MODE_W(MODE_W), .POS_W(POS_W), .ADDR_W(ADDR_W)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .active(active), .pos(rd_pos), .mode(rd_mode),
    .addr(mem_addr)
  );

  ccs_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .active(active), .mem_rdata(mem_rdata),
    .ctl_out(ctl_out)
  );

  assign mem_rd_en = active;

  p_wrap_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wrap && !frame_sync) |=> (mem_rd_en && mem_addr == ADDR_W'(1)));

endmodule

// File: tb/ccs_serializer_bench.sv
module ccs_serializer_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_sync = 1'b0;
  logic [1:0]  rate_sel = 2'd0;
  logic        mem_rdata = 1'b0;
  logic [10:0] mem_addr;
  logic        mem_rd_en;
  logic        ctl_out;

  always #4 clk = ~clk;

  ccs_serializer u_ccs_serializer (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rate_sel(rate_sel),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .ctl_out(ctl_out)
  );

  // Flag memory with a one-cycle synchronous read
  logic flags [2048];
  always_ff @(posedge clk) mem_rdata <= flags[mem_addr];

  typedef struct {
    logic  b;
    int    pos;
    string tag;
  } item_t;
  item_t sbq[$];

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected flag for position p in select code m, built from R2, R3 and R4
  function automatic logic exp_bit(input int p, input int m);
    int md;
    int chn;
    int st;
    int sl;
    int pv;
    md  = (m > 2) ? 2 : m;
    chn = 32 * (1 << md);
    st  = p & 15;
    sl  = p >> 4;
    pv  = (sl == chn - 1) ? 0 : sl + 1;
    return flags[st * chn + pv];
  endfunction

  function automatic int frame_len(input int m);
    return 16 * 32 * (1 << ((m > 2) ? 2 : m));
  endfunction

  // Driver: pulse, queue n expected bits (wrapping per R7), optionally change rate mid-frame (R8)
  task automatic start_frame(input int m, input int n, input int alt, input string tag);
    int len;
    len = frame_len(m);
    rate_sel   = 2'(m);
    frame_sync = 1'b1;
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.b   = exp_bit(k % len, m);
      it.pos = k;
      it.tag = tag;
      sbq.push_back(it);
    end
    @(negedge clk);
    frame_sync = 1'b0;
    if (alt >= 0) rate_sel = 2'(alt);
    repeat (n - 1) @(negedge clk);
  endtask

  // Monitor: one item per rising edge, sampled 2 ns later (R6 timing, R3/R5 values)
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check(ctl_out === it.b, {it.tag, " flag bit"}, int'(ctl_out), int'(it.b));
      check(mem_rd_en === 1'b1, {it.tag, " R6 read strobe"}, int'(mem_rd_en), 1);
    end
  end

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int a = 0; a < 2048; a++) flags[a] = logic'($countones(a * 37 + 11) & 1);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet before the first pulse, even while rate_sel moves
    for (int i = 0; i < 10; i++) begin
      rate_sel = 2'(i);
      @(negedge clk);
      check(ctl_out === 1'b0, "R1 ctl_out idle", int'(ctl_out), 0);
      check(mem_rd_en === 1'b0, "R1 rd_en idle", int'(mem_rd_en), 0);
    end
    start_frame(0, 2 * 512, -1, "R7 mode0 free-run");      // R3 R4 R5 R6 R7
    start_frame(1, 1024, 0, "R8 mode1 rate change ignored");
    start_frame(2, 2048, -1, "R4 mode2");
    start_frame(3, 2048 + 32, -1, "R2 code3 as mode2 wrap");
    start_frame(0, 100, -1, "R9 partial frame");
    start_frame(0, 512 + 16, -1, "R9 restart");
    start_frame(1, 1024 + 16, 2, "R2 mode1 length");
    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R6 queue drained", sbq.size(), 0);
    report();
  end

endmodule